// File: doc/BRIEF.md
# Group-Filtered Memory Barrier Gate

This block sits next to a load/store queue and enforces selective ordering fences. Memory operations are offered in program order. Each one carries a class (load, store, or atomic, where an atomic counts as both) and a 3-bit coherence group. An operation that is allowed to start takes a tracking slot. The slot is freed when the queue reports the operation complete, and completions may arrive in any order. A barrier carries three things:

- a 4-bit pairing mask that chooses which older-class to younger-class pairings it orders;
- a mask of older groups;
- a mask of younger groups.

When the block accepts a barrier, it stores a snapshot of the in-flight older operations the barrier covers, kept as separate load and store slot sets. Completion reports clear the snapshot bit by bit.

While a barrier's snapshot is non-empty, a new operation is refused (`op_issue_ok` low) if two conditions hold: its group is in the barrier's younger mask, and a set pairing bit links its class to a class still present in the snapshot. Anything the barrier does not select passes freely. A barrier signals retirement for one cycle in the first cycle its snapshot is empty, and its entry becomes free in the following cycle. Same-address ordering and the rule about unresolved addresses stay with the load/store queue.

Each barrier entry is a small state machine with three states:

- `BE_IDLE`: the entry is free.
- `BE_WAIT`: the snapshot is non-empty and the entry blocks matching operations.
- `BE_DONE`: the retire pulse is high.

Its transitions are:

- ACCEPT_HOLD (`BE_IDLE`→`BE_WAIT`): the barrier is accepted with a non-empty snapshot.
- ACCEPT_CLEAR (`BE_IDLE`→`BE_DONE`): the barrier is accepted with an empty snapshot.
- DRAIN (`BE_WAIT`→`BE_DONE`): the last covered operation completes.
- RELEASE (`BE_DONE`→`BE_IDLE`): the entry frees itself after the retire cycle.

Top module: `mbg_gate`

## Requirements
- R1: After reset every slot and barrier entry is free. `op_issue_ok` is 1 for any operation, `op_slot` is 0, `bar_ready` is 1, `bar_id` is 0 and `bar_retire` is all zeros.
- R2: An accepted operation (`op_valid` and `op_issue_ok`) takes the lowest-numbered free slot, which is shown on `op_slot`.
  - `op_issue_ok` is 0 while all slots are busy.
  - A completion (`cmp_valid`, `cmp_slot`) frees its slot from the next cycle.
  - A completion naming a free or non-existent slot is ignored.
- R3: `bar_ready` is 1 exactly when some barrier entry is idle, and `bar_id` gives the lowest idle entry. On acceptance the barrier snapshots, as older loads, the busy slots that meet all three of these conditions:
  - the slot's group bit is set in `bar_old_grp`;
  - the slot has the load class;
  - `bar_order[0]` or `bar_order[1]` is set.

  Older stores are snapshotted the same way, using the store class and `bar_order[2]` or `bar_order[3]`.
- R4: The pairing bits are: `bar_order[0]` load→load, `bar_order[1]` load→store, `bar_order[2]` store→load, `bar_order[3]` store→store. An operation whose group is set in a waiting barrier's younger mask is refused in either of these cases:
  - it has the load class, and bit 0 is set with older loads pending or bit 2 is set with older stores pending;
  - it has the store class, and bit 1 is set with older loads pending or bit 3 is set with older stores pending.
- R5: An operation that no waiting barrier selects, by group or by class, is refused only when no slot is free.
- R6: `op_kind` bit 0 is the load class and bit 1 is the store class, so 2'b11 is an atomic. An atomic is refused if either of its classes is blocked, and it enters both snapshots of a later barrier.
- R7: `bar_retire[b]` is high for exactly one cycle: the first cycle in which both snapshots of entry b are empty, whatever order the completions arrive in. A barrier accepted with empty snapshots pulses in the cycle after acceptance. The entry is idle again in the cycle after the pulse.
- R8: A barrier with `bar_order` 4'hF and both group masks 8'hFF refuses every operation until all operations older than it have completed.
- R9: An operation and a barrier accepted in the same cycle are ordered operation first. The operation enters that barrier's snapshot and is not blocked by it.
- R10: A slot completing in the same cycle a barrier is accepted is left out of that barrier's snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is offered this cycle |
| op_kind | input | 2 | Class bits: [0] load, [1] store |
| op_group | input | GW | Coherence group of the operation |
| op_issue_ok | output | 1 | Operation may start now |
| op_slot | output | SW | Slot the accepted operation takes |
| cmp_valid | input | 1 | Completion report valid |
| cmp_slot | input | SW | Slot that completed |
| bar_valid | input | 1 | A barrier is offered this cycle |
| bar_order | input | 4 | Pairing mask (LL, LS, SL, SS at bits 0..3) |
| bar_old_grp | input | 2**GW | Older-side group mask |
| bar_young_grp | input | 2**GW | Younger-side group mask |
| bar_ready | output | 1 | A barrier entry is free |
| bar_id | output | BW | Entry the accepted barrier takes |
| bar_retire | output | NBAR | One-cycle retire pulse per entry |

## Verification
The bench builds the gate with six slots, two barrier entries and 3-bit groups. With only six slots, random traffic often fills every slot, so refusal for lack of a free slot gets exercised. The slot count is not a power of two, so completion indices 6 and 7 address slots that do not exist and must be ignored. Two entries make the state where both barriers are pending, and no new barrier can enter, a common one. Eight groups against random masks give frequent mixes of selected and unselected groups and classes.

// File: rtl/mbg_pkg.sv
package mbg_pkg;

    typedef enum logic [1:0] {
        BE_IDLE = 2'd0,
        BE_WAIT = 2'd1,
        BE_DONE = 2'd2
    } be_state_t;

    // bit positions inside the pairing mask (older -> younger)
    localparam int ORD_LL = 0;
    localparam int ORD_LS = 1;
    localparam int ORD_SL = 2;
    localparam int ORD_SS = 3;

    // bit positions inside the operation class field
    localparam int KIND_LD = 0;
    localparam int KIND_ST = 1;

endpackage

// File: rtl/mbg_slot_table.sv
module mbg_slot_table #(
    parameter int NSLOT = 8,
    parameter int GW    = 3,
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_en,
    input  logic                     alloc_ld,
    input  logic                     alloc_st,
    input  logic [GW-1:0]            alloc_grp,
    input  logic                     cmp_valid,
    input  logic [SW-1:0]            cmp_slot,
    output logic [NSLOT-1:0]         busy,
    output logic [NSLOT-1:0]         is_ld,
    output logic [NSLOT-1:0]         is_st,
    output logic [NSLOT-1:0][GW-1:0] grp,
    output logic                     free_any,
    output logic [SW-1:0]            free_idx,
    output logic [NSLOT-1:0]         alloc_mask,
    output logic [NSLOT-1:0]         cmp_mask
);

    // lowest-numbered free slot
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                free_any = 1'b1;
                free_idx = SW'(i);
            end
        end
    end

    always_comb begin
        alloc_mask = '0;
        if (alloc_en && free_any) begin
            alloc_mask = NSLOT'(1) << free_idx;
        end
        cmp_mask = '0;
        if (cmp_valid) begin
            cmp_mask = (NSLOT'(1) << cmp_slot) & busy;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= '0;
            is_ld <= '0;
            is_st <= '0;
            grp   <= '0;
        end else begin
            busy <= (busy & ~cmp_mask) | alloc_mask;
            for (int i = 0; i < NSLOT; i++) begin
                if (alloc_mask[i]) begin
                    is_ld[i] <= alloc_ld;
                    is_st[i] <= alloc_st;
                    grp[i]   <= alloc_grp;
                end
            end
        end
    end

endmodule

// File: rtl/mbg_snap_build.sv
module mbg_snap_build
    import mbg_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int GW    = 3,
    localparam int NG   = 1 << GW
) (
    input  logic [NSLOT-1:0]         busy,
    input  logic [NSLOT-1:0]         is_ld,
    input  logic [NSLOT-1:0]         is_st,
    input  logic [NSLOT-1:0][GW-1:0] grp,
    input  logic [NSLOT-1:0]         alloc_mask,
    input  logic                     alloc_ld,
    input  logic                     alloc_st,
    input  logic [GW-1:0]            alloc_grp,
    input  logic [NSLOT-1:0]         cmp_mask,
    input  logic [3:0]               order,
    input  logic [NG-1:0]            old_grp,
    output logic [NSLOT-1:0]         snap_ld,
    output logic [NSLOT-1:0]         snap_st
);

    logic want_ld;
    logic want_st;

    assign want_ld = order[ORD_LL] | order[ORD_LS];
    assign want_st = order[ORD_SL] | order[ORD_SS];

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic          live;
        logic          c_ld;
        logic          c_st;
        logic [GW-1:0] c_grp;

        // a slot filled this cycle is older than the barrier
        assign live  = (busy[i] | alloc_mask[i]) & ~cmp_mask[i];
        assign c_ld  = alloc_mask[i] ? alloc_ld  : is_ld[i];
        assign c_st  = alloc_mask[i] ? alloc_st  : is_st[i];
        assign c_grp = alloc_mask[i] ? alloc_grp : grp[i];

        assign snap_ld[i] = live & old_grp[c_grp] & c_ld & want_ld;
        assign snap_st[i] = live & old_grp[c_grp] & c_st & want_st;
    end

endmodule

// File: rtl/mbg_barrier_entry.sv
module mbg_barrier_entry
    import mbg_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int NG    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [3:0]       order,
    input  logic [NG-1:0]    young_grp,
    input  logic [NSLOT-1:0] init_ld,
    input  logic [NSLOT-1:0] init_st,
    input  logic [NSLOT-1:0] cmp_mask,
    input  logic             op_ld,
    input  logic             op_st,
    input  logic [NG-1:0]    op_grp_oh,
    output logic             block,
    output logic             busy,
    output logic             waiting,
    output logic             retire
);

    be_state_t        st_q, st_n;
    logic [NSLOT-1:0] ld_q, ld_n;
    logic [NSLOT-1:0] ss_q, ss_n;
    logic [3:0]       ord_q;
    logic [NG-1:0]    yng_q;

    // next state
    always_comb begin
        st_n = st_q;
        ld_n = ld_q;
        ss_n = ss_q;
        unique case (st_q)
            BE_IDLE: begin
                if (accept) begin
                    ld_n = init_ld;
                    ss_n = init_st;
                    st_n = ((|init_ld) || (|init_st)) ? BE_WAIT : BE_DONE;
                end
            end
            BE_WAIT: begin
                ld_n = ld_q & ~cmp_mask;
                ss_n = ss_q & ~cmp_mask;
                if (!(|ld_n) && !(|ss_n)) begin
                    st_n = BE_DONE;
                end
            end
            BE_DONE: begin
                st_n = BE_IDLE;
            end
            default: begin
                st_n = BE_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BE_IDLE;
            ld_q  <= '0;
            ss_q  <= '0;
            ord_q <= '0;
            yng_q <= '0;
        end else begin
            st_q <= st_n;
            ld_q <= ld_n;
            ss_q <= ss_n;
            if (st_q == BE_IDLE && accept) begin
                ord_q <= order;
                yng_q <= young_grp;
            end
        end
    end

    // outputs
    always_comb begin
        logic ld_pend;
        logic st_pend;
        logic hit;
        ld_pend = |ld_q;
        st_pend = |ss_q;
        hit     = |(yng_q & op_grp_oh);
        busy    = (st_q != BE_IDLE);
        waiting = (st_q == BE_WAIT);
        retire  = (st_q == BE_DONE);
        block   = waiting && hit &&
                  ((op_ld && ((ord_q[ORD_LL] && ld_pend) || (ord_q[ORD_SL] && st_pend))) ||
                   (op_st && ((ord_q[ORD_LS] && ld_pend) || (ord_q[ORD_SS] && st_pend))));
    end

endmodule

// File: rtl/mbg_gate.sv
module mbg_gate
    import mbg_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int NBAR  = 4,
    parameter int GW    = 3,
    localparam int NG   = 1 << GW,
    localparam int SW   = $clog2(NSLOT),
    localparam int BW   = $clog2(NBAR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [1:0]      op_kind,
    input  logic [GW-1:0]   op_group,
    output logic            op_issue_ok,
    output logic [SW-1:0]   op_slot,
    input  logic            cmp_valid,
    input  logic [SW-1:0]   cmp_slot,
    input  logic            bar_valid,
    input  logic [3:0]      bar_order,
    input  logic [NG-1:0]   bar_old_grp,
    input  logic [NG-1:0]   bar_young_grp,
    output logic            bar_ready,
    output logic [BW-1:0]   bar_id,
    output logic [NBAR-1:0] bar_retire
);

    logic [NSLOT-1:0]         slot_busy;
    logic [NSLOT-1:0]         slot_ld;
    logic [NSLOT-1:0]         slot_st;
    logic [NSLOT-1:0][GW-1:0] slot_grp;
    logic                     free_any;
    logic [SW-1:0]            free_idx;
    logic [NSLOT-1:0]         alloc_mask;
    logic [NSLOT-1:0]         cmp_mask;
    logic [NSLOT-1:0]         init_ld;
    logic [NSLOT-1:0]         init_st;
    logic [NBAR-1:0]          bar_block;
    logic [NBAR-1:0]          bar_busy;
    logic [NBAR-1:0]          bar_wait;
    logic [NG-1:0]            op_grp_oh;
    logic                     alloc_en;
    logic                     bar_take;

    assign op_grp_oh   = NG'(1) << op_group;
    assign op_issue_ok = free_any && !(|bar_block);
    assign op_slot     = free_idx;
    assign alloc_en    = op_valid && op_issue_ok;

    // lowest idle barrier entry
    always_comb begin
        bar_ready = 1'b0;
        bar_id    = '0;
        for (int b = NBAR - 1; b >= 0; b--) begin
            if (!bar_busy[b]) begin
                bar_ready = 1'b1;
                bar_id    = BW'(b);
            end
        end
    end

    assign bar_take = bar_valid && bar_ready;

    mbg_slot_table #(.NSLOT(NSLOT), .GW(GW)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (alloc_en),
        .alloc_ld   (op_kind[KIND_LD]),
        .alloc_st   (op_kind[KIND_ST]),
        .alloc_grp  (op_group),
        .cmp_valid  (cmp_valid),
        .cmp_slot   (cmp_slot),
        .busy       (slot_busy),
        .is_ld      (slot_ld),
        .is_st      (slot_st),
        .grp        (slot_grp),
        .free_any   (free_any),
        .free_idx   (free_idx),
        .alloc_mask (alloc_mask),
        .cmp_mask   (cmp_mask)
    );

    mbg_snap_build #(.NSLOT(NSLOT), .GW(GW)) u_snap (
        .busy       (slot_busy),
        .is_ld      (slot_ld),
        .is_st      (slot_st),
        .grp        (slot_grp),
        .alloc_mask (alloc_mask),
        .alloc_ld   (op_kind[KIND_LD]),
        .alloc_st   (op_kind[KIND_ST]),
        .alloc_grp  (op_group),
        .cmp_mask   (cmp_mask),
        .order      (bar_order),
        .old_grp    (bar_old_grp),
        .snap_ld    (init_ld),
        .snap_st    (init_st)
    );

    for (genvar b = 0; b < NBAR; b++) begin : g_bar
        mbg_barrier_entry #(.NSLOT(NSLOT), .NG(NG)) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .accept    (bar_take && (bar_id == BW'(b))),
            .order     (bar_order),
            .young_grp (bar_young_grp),
            .init_ld   (init_ld),
            .init_st   (init_st),
            .cmp_mask  (cmp_mask),
            .op_ld     (op_kind[KIND_LD]),
            .op_st     (op_kind[KIND_ST]),
            .op_grp_oh (op_grp_oh),
            .block     (bar_block[b]),
            .busy      (bar_busy[b]),
            .waiting   (bar_wait[b]),
            .retire    (bar_retire[b])
        );
    end

endmodule

// File: rtl/mbg_gate_sva.sv
module mbg_gate_sva #(
    parameter int NSLOT = 8,
    parameter int NBAR  = 4,
    parameter int GW    = 3,
    localparam int NG   = 1 << GW,
    localparam int SW   = $clog2(NSLOT),
    localparam int BW   = $clog2(NBAR)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [1:0]      op_kind,
    input logic            op_issue_ok,
    input logic [SW-1:0]   op_slot,
    input logic            cmp_valid,
    input logic [SW-1:0]   cmp_slot,
    input logic            bar_valid,
    input logic [3:0]      bar_order,
    input logic [NG-1:0]   bar_old_grp,
    input logic [NG-1:0]   bar_young_grp,
    input logic            bar_ready,
    input logic [BW-1:0]   bar_id,
    input logic [NBAR-1:0] bar_retire,
    input logic [NSLOT-1:0] slot_busy,
    input logic [NBAR-1:0] bar_busy,
    input logic [NBAR-1:0] bar_wait
);

    p_alloc_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_issue_ok |=> slot_busy[$past(op_slot)]);

    p_no_issue_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (&slot_busy) |-> !op_issue_ok);

    p_cmp_frees_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && slot_busy[cmp_slot] |=> !slot_busy[$past(cmp_slot)]);

    p_bar_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bar_valid && bar_ready |=> bar_busy[$past(bar_id)]);

    p_block_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !op_issue_ok && !(&slot_busy) |-> (|bar_wait));

    p_kind_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (op_kind != 2'b00));

    p_retire_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|bar_retire) |=> ((bar_retire & $past(bar_retire)) == '0));

    p_retire_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_retire & ~bar_busy) == '0);

    p_fence_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bar_valid && bar_ready && (&bar_order) && (&bar_old_grp) &&
        (&bar_young_grp) && (|slot_busy) && !cmp_valid
        |=> (op_valid |-> !op_issue_ok));

endmodule

bind mbg_gate mbg_gate_sva #(.NSLOT(NSLOT), .NBAR(NBAR), .GW(GW)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_valid      (op_valid),
    .op_kind       (op_kind),
    .op_issue_ok   (op_issue_ok),
    .op_slot       (op_slot),
    .cmp_valid     (cmp_valid),
    .cmp_slot      (cmp_slot),
    .bar_valid     (bar_valid),
    .bar_order     (bar_order),
    .bar_old_grp   (bar_old_grp),
    .bar_young_grp (bar_young_grp),
    .bar_ready     (bar_ready),
    .bar_id        (bar_id),
    .bar_retire    (bar_retire),
    .slot_busy     (slot_busy),
    .bar_busy      (bar_busy),
    .bar_wait      (bar_wait)
);

// File: tb/mbg_gate_test.sv
module mbg_gate_test;

    localparam int NS = 6;
    localparam int NB = 2;
    localparam int GW = 3;
    localparam int NG = 8;
    localparam int SW = 3;
    localparam int BW = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [1:0]    op_kind = 2'b01;
    logic [GW-1:0] op_group = '0;
    logic          op_issue_ok;
    logic [SW-1:0] op_slot;
    logic          cmp_valid = 1'b0;
    logic [SW-1:0] cmp_slot = '0;
    logic          bar_valid = 1'b0;
    logic [3:0]    bar_order = '0;
    logic [NG-1:0] bar_old_grp = '0;
    logic [NG-1:0] bar_young_grp = '0;
    logic          bar_ready;
    logic [BW-1:0] bar_id;
    logic [NB-1:0] bar_retire;

    always #10 clk = ~clk;

    mbg_gate #(.NSLOT(NS), .NBAR(NB), .GW(GW)) uut (
        .clk(clk), .rst_n(rst_n),
        .op_valid(op_valid), .op_kind(op_kind), .op_group(op_group),
        .op_issue_ok(op_issue_ok), .op_slot(op_slot),
        .cmp_valid(cmp_valid), .cmp_slot(cmp_slot),
        .bar_valid(bar_valid), .bar_order(bar_order),
        .bar_old_grp(bar_old_grp), .bar_young_grp(bar_young_grp),
        .bar_ready(bar_ready), .bar_id(bar_id), .bar_retire(bar_retire)
    );

    int    errors = 0;
    int    checks = 0;
    string ph = "";

    // reference model state
    bit            m_busy[NS];
    bit            m_ld[NS];
    bit            m_st[NS];
    int            m_grp[NS];
    int            m_bst[NB];   // 0 free, 1 pending, 2 retiring
    logic [NS-1:0] m_ldm[NB];
    logic [NS-1:0] m_stm[NB];
    logic [3:0]    m_ord[NB];
    logic [NG-1:0] m_yng[NB];

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_blocked(input logic [1:0] k, input int g);
        for (int b = 0; b < NB; b++) begin
            if (m_bst[b] == 1 && m_yng[b][g]) begin
                bit lp = (m_ldm[b] != 0);
                bit sp = (m_stm[b] != 0);
                if (k[0] && ((m_ord[b][0] && lp) || (m_ord[b][2] && sp))) return 1'b1;
                if (k[1] && ((m_ord[b][1] && lp) || (m_ord[b][3] && sp))) return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    task automatic step(input bit ov, input logic [1:0] ok, input int og,
                        input bit cv, input int cs,
                        input bit bv, input logic [3:0] bo,
                        input logic [7:0] bold, input logic [7:0] byng);
        int    fi, bi, cm;
        bit    blk, eok;
        string tag;
        @(negedge clk);
        op_valid = ov; op_kind = ok; op_group = og[GW-1:0];
        cmp_valid = cv; cmp_slot = cs[SW-1:0];
        bar_valid = bv; bar_order = bo; bar_old_grp = bold; bar_young_grp = byng;
        #1;
        fi = -1;
        for (int i = 0; i < NS; i++) if (!m_busy[i] && fi < 0) fi = i;
        blk = m_blocked(ok, og);
        eok = (fi >= 0) && !blk;
        if (ph != "") tag = ph;
        else if (fi < 0) tag = "R2";
        else if (blk) tag = "R4";
        else if (ok == 2'b11) tag = "R6";
        else tag = "R5";
        chk(tag, int'(op_issue_ok), int'(eok));
        if (eok) chk("R2", int'(op_slot), fi);
        bi = -1;
        for (int b = 0; b < NB; b++) if (m_bst[b] == 0 && bi < 0) bi = b;
        chk("R3", int'(bar_ready), int'(bi >= 0));
        if (bi >= 0) chk("R3", int'(bar_id), bi);
        for (int b = 0; b < NB; b++) chk("R7", int'(bar_retire[b]), int'(m_bst[b] == 2));
        // advance the model
        cm = -1;
        if (cv && cs < NS) if (m_busy[cs]) cm = cs;
        for (int b = 0; b < NB; b++) begin
            if (m_bst[b] == 2) m_bst[b] = 0;
            else if (m_bst[b] == 1) begin
                if (cm >= 0) begin
                    m_ldm[b][cm] = 1'b0;
                    m_stm[b][cm] = 1'b0;
                end
                if (m_ldm[b] == 0 && m_stm[b] == 0) m_bst[b] = 2;
            end
        end
        if (ov && eok) begin
            m_busy[fi] = 1'b1; m_ld[fi] = ok[0]; m_st[fi] = ok[1]; m_grp[fi] = og;
        end
        if (bv && bi >= 0) begin
            m_ldm[bi] = '0; m_stm[bi] = '0;
            m_ord[bi] = bo; m_yng[bi] = byng;
            for (int i = 0; i < NS; i++) begin
                if (m_busy[i] && i != cm && bold[m_grp[i]]) begin
                    if (m_ld[i] && (bo[0] || bo[1])) m_ldm[bi][i] = 1'b1;
                    if (m_st[i] && (bo[2] || bo[3])) m_stm[bi][i] = 1'b1;
                end
            end
            m_bst[bi] = (m_ldm[bi] != 0 || m_stm[bi] != 0) ? 1 : 2;
        end
        if (cm >= 0) m_busy[cm] = 1'b0;
    endtask

    task automatic idle();
        step(0, 2'b01, 0, 0, 0, 0, 4'h0, 8'h00, 8'h00);
    endtask

    task automatic op(input logic [1:0] k, input int g);
        step(1, k, g, 0, 0, 0, 4'h0, 8'h00, 8'h00);
    endtask

    task automatic done(input int s);
        step(0, 2'b01, 0, 1, s, 0, 4'h0, 8'h00, 8'h00);
    endtask

    task automatic bar(input logic [3:0] o, input logic [7:0] od, input logic [7:0] yg);
        step(0, 2'b01, 0, 0, 0, 1, o, od, yg);
    endtask

    task automatic drain();
        for (int i = 0; i < NS; i++) if (m_busy[i]) done(i);
        repeat (3) idle();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NS; i++) begin
            m_busy[i] = 0; m_ld[i] = 0; m_st[i] = 0; m_grp[i] = 0;
        end
        for (int b = 0; b < NB; b++) begin
            m_bst[b] = 0; m_ldm[b] = '0; m_stm[b] = '0; m_ord[b] = '0; m_yng[b] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", int'(op_issue_ok), 1);
        chk("R1", int'(op_slot), 0);
        chk("R1", int'(bar_ready), 1);
        chk("R1", int'(bar_id), 0);
        chk("R1", int'(bar_retire), 0);

        // R9: op and load->load barrier together; the op is older
        ph = "R9";
        step(1, 2'b01, 1, 0, 0, 1, 4'b0001, 8'h02, 8'h02);
        op(2'b01, 1);            // younger load in group 1: blocked
        op(2'b10, 1);            // store not selected by LL: passes
        // R10: complete slot 0 while a full fence is accepted
        ph = "R10";
        step(0, 2'b01, 0, 1, 0, 1, 4'hF, 8'hFF, 8'hFF);
        ph = "";
        idle();                  // entry 0 retires here
        op(2'b01, 1);            // fence still waits on slot 1
        done(1);
        idle();
        drain();

        // R8 full fence with out-of-order completions
        ph = "R8";
        op(2'b01, 0);
        op(2'b10, 4);
        op(2'b11, 7);
        bar(4'hF, 8'hFF, 8'hFF);
        op(2'b01, 3);
        op(2'b10, 5);
        done(1);
        op(2'b11, 6);
        done(0);
        op(2'b01, 2);
        done(2);
        op(2'b01, 2);
        ph = "";
        drain();

        // R6 atomics in both snapshots and both blocking classes
        ph = "R6";
        op(2'b11, 2);
        bar(4'b1000, 8'h04, 8'h08);
        op(2'b10, 3);
        op(2'b01, 3);
        op(2'b11, 3);
        ph = "";
        drain();

        // R5 unselected group or class passes
        ph = "R5";
        op(2'b01, 0);
        bar(4'b0001, 8'h01, 8'h01);
        op(2'b10, 0);
        op(2'b01, 5);
        ph = "R4";
        op(2'b01, 0);
        ph = "";
        drain();

        // R2 slot exhaustion and ignored completions
        ph = "R2";
        for (int i = 0; i < NS; i++) op(2'b01, 6);
        op(2'b01, 6);
        done(7);
        op(2'b01, 6);
        done(3);
        op(2'b10, 1);
        ph = "";
        drain();
        done(2);
        op(2'b01, 0);
        drain();

        // R7 barrier with an empty snapshot
        ph = "R7";
        bar(4'hF, 8'h00, 8'hFF);
        idle();
        idle();
        ph = "";

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 4) != 0, 2'(1 + ($urandom % 3)), int'($urandom % 8),
                 ($urandom % 2) == 1, int'($urandom % 8),
                 ($urandom % 8) == 0, 4'($urandom), 8'($urandom), 8'($urandom));
        end
        drain();

        summary();
        $finish;
    end

endmodule